// File: doc/BRIEF.md
# Masked Memory Checksum Accumulator

This block forms a 16-bit device checksum from a stream of memory items that a programming or verification engine presents one per clock. Each beat carries a 16-bit value, a two-bit region tag, an 8-bit mask that applies to configuration bytes, and an end-of-stream marker. A valid/ready handshake moves the beats. The block does not fetch memory and does not look up masks. The engine supplies both with every item.

Each region is treated differently. A program word counts in full. A configuration byte counts only in the bits its mask keeps. An ID word counts only while the code-protect input is high. A data EEPROM item never counts. The sum wraps at 16 bits. A start pulse opens a new computation. After the beat marked last is accepted, the block raises a one-cycle done flag and the final sum is on the output.

Top module: `mem_cksum_accum`

## Requirements
- R1: While `rst_n` is low, `sum_o` is 0, `done_o` is 0 and `in_ready_o` is 0. Within three clocks after reset is released, `in_ready_o` goes to 1 and then stays at 1.
- R2: A beat with region code 0 (program word) adds all 16 bits of `in_data_i` to the sum. Any carry out of bit 15 is lost, so the sum is taken modulo 65536.
- R3: A beat with region code 1 (configuration byte) adds `in_data_i[7:0] & in_mask_i`, zero-extended to 16 bits. `in_data_i[15:8]` has no effect.
- R4: A beat with region code 2 (ID location) adds all 16 bits of `in_data_i` when `prot_on_i` is 1. When `prot_on_i` is 0 the beat is still accepted but adds nothing.
- R5: A beat with region code 3 (data EEPROM) is accepted and never changes the sum.
- R6: A start pulse sets the sum to 0. If a beat is accepted in the same cycle as start, that beat becomes the first term of the new sum.
- R7: A cycle in which `in_valid_i` is 0 and start is 0 leaves `sum_o` unchanged, whatever the other inputs carry.
- R8: On the clock after an accepted beat with `in_last_i` set, `done_o` is 1 for exactly one cycle, and `sum_o` then holds the checksum of every beat since the last start.
- R9: `sum_o` shows the running total on the clock after each accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Clears the sum and opens a computation |
| in_valid_i | input | 1 | Beat valid |
| in_ready_o | output | 1 | Beat ready; high from shortly after reset |
| in_data_i | input | 16 | Item value |
| in_region_i | input | 2 | Region code: 0 program, 1 config, 2 ID, 3 EEPROM |
| in_mask_i | input | 8 | Mask applied to configuration bytes |
| in_last_i | input | 1 | Marks the final beat of the stream |
| prot_on_i | input | 1 | High when some memory block is code-protected |
| sum_o | output | 16 | Running and final checksum |
| done_o | output | 1 | One-cycle flag that the checksum is final |

## Verification
Two things can happen in the same cycle: a start pulse and an accepted beat. The bench provokes this after the sum has been made nonzero. It drives start and a program word on the same edge, then checks that the next sum equals that word alone, which rules out both the old total and a discarded beat. A last beat that lands right after this combined cycle then checks that done reports a total built on the fresh start.

// File: rtl/mem_cksum_pkg.sv
package mem_cksum_pkg;
  typedef enum logic [1:0] {
    RG_PROG = 2'd0,
    RG_CFG  = 2'd1,
    RG_ID   = 2'd2,
    RG_EE   = 2'd3
  } region_e;
endpackage

// File: rtl/mem_cksum_rstsync.sv
module mem_cksum_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];

  AST_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_s_n |=> rst_s_n); // R1
endmodule

// File: rtl/mem_cksum_term.sv
module mem_cksum_term
  import mem_cksum_pkg::*;
#(
  parameter int DW = 16,
  parameter int MW = 8
) (
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    region_i,
  input  logic [MW-1:0] mask_i,
  input  logic          prot_i,
  output logic [DW-1:0] term_o
);
  localparam int PADW = DW - MW;

  logic [MW-1:0] cfg_masked;

  for (genvar g = 0; g < MW; g++) begin : g_mask
    assign cfg_masked[g] = data_i[g] & mask_i[g];
  end

  always_comb begin
    term_o = '0;
    case (region_e'(region_i))
      RG_PROG: term_o = data_i;
      RG_CFG:  term_o = {{PADW{1'b0}}, cfg_masked};
      RG_ID:   term_o = prot_i ? data_i : '0;
      default: term_o = '0;
    endcase
  end

  always_comb begin
    if (region_i == RG_EE)
      AST_EE_NO_TERM: assert (term_o == '0); // R5
    if (region_i == RG_ID && !prot_i)
      AST_ID_GATED: assert (term_o == '0); // R4
    if (region_i == RG_CFG)
      AST_CFG_INSIDE_MASK: assert ((term_o & ~{{PADW{1'b0}}, mask_i}) == '0); // R3
  end
endmodule

// File: rtl/mem_cksum_acc.sv
module mem_cksum_acc #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_s_n,
  input  logic          start_i,
  input  logic          fire_i,
  input  logic          last_i,
  input  logic [DW-1:0] term_i,
  output logic [DW-1:0] sum_o,
  output logic          done_o
);
  logic [DW-1:0] sum_q, sum_d, base;
  logic          done_q, done_d;
  logic          sum_en;

  always_comb begin
    base   = start_i ? '0 : sum_q;
    sum_en = start_i | fire_i;
    sum_d  = base + (fire_i ? term_i : '0);
    done_d = fire_i & last_i;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      sum_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (sum_en) sum_q <= sum_d;
      done_q <= done_d;
    end
  end

  assign sum_o  = sum_q;
  assign done_o = done_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (start_i && !fire_i) |=> (sum_o == '0)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!start_i && !fire_i) |=> $stable(sum_o)); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fire_i && last_i) |=> done_o); // R8
  AST_DONE_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(fire_i && last_i) |=> !done_o); // R8
endmodule

// File: rtl/mem_cksum_accum.sv
module mem_cksum_accum #(
  parameter int DW = 16,
  parameter int MW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [15:0]   in_data_i,
  input  logic [1:0]    in_region_i,
  input  logic [7:0]    in_mask_i,
  input  logic          in_last_i,
  input  logic          prot_on_i,
  output logic [15:0]   sum_o,
  output logic          done_o
);
  logic          rst_s_n;
  logic          fire;
  logic [DW-1:0] term;

  mem_cksum_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign in_ready_o = rst_s_n;
  assign fire       = in_valid_i & in_ready_o;

  mem_cksum_term #(.DW(DW), .MW(MW)) u_term (
    .data_i   (in_data_i),
    .region_i (in_region_i),
    .mask_i   (in_mask_i),
    .prot_i   (prot_on_i),
    .term_o   (term)
  );

  mem_cksum_acc #(.DW(DW)) u_acc (
    .clk     (clk),
    .rst_s_n (rst_s_n),
    .start_i (start_i),
    .fire_i  (fire),
    .last_i  (in_last_i),
    .term_i  (term),
    .sum_o   (sum_o),
    .done_o  (done_o)
  );

  AST_PROG_FULL_ADD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fire && !start_i && in_region_i == 2'd0)
      |=> (sum_o == $past(sum_o) + $past(in_data_i))); // R2
endmodule

// File: tb/mem_cksum_accum_bench.sv
module mem_cksum_accum_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, in_valid_i, in_last_i, prot_on_i;
  logic        in_ready_o, done_o;
  logic [15:0] in_data_i, sum_o;
  logic [1:0]  in_region_i;
  logic [7:0]  in_mask_i;

  int total = 0;
  int bad   = 0;
  logic [15:0] exp_sum;
  logic [15:0] exp_q[$];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mem_cksum_accum u_mem_cksum_accum (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .in_data_i(in_data_i), .in_region_i(in_region_i),
    .in_mask_i(in_mask_i), .in_last_i(in_last_i), .prot_on_i(prot_on_i),
    .sum_o(sum_o), .done_o(done_o)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] contrib(logic [1:0] rg, logic [15:0] d,
                                          logic [7:0] m, logic p);
    case (rg)
      2'd0: return d;
      2'd1: return {8'h00, d[7:0] & m};
      2'd2: return p ? d : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  task automatic idle();
    start_i = 0; in_valid_i = 0; in_last_i = 0;
    @(negedge clk);
  endtask

  task automatic send(logic st, logic [1:0] rg, logic [15:0] d,
                      logic [7:0] m, logic lst);
    start_i = st; in_valid_i = 1; in_region_i = rg;
    in_data_i = d; in_mask_i = m; in_last_i = lst;
    if (st) exp_sum = 16'h0;
    exp_sum = exp_sum + contrib(rg, d, m, prot_on_i);
    if (lst) exp_q.push_back(exp_sum);
    @(negedge clk);
    start_i = 0; in_valid_i = 0; in_last_i = 0;
  endtask

  task automatic do_start();
    start_i = 1; in_valid_i = 0; exp_sum = 16'h0;
    @(negedge clk);
    start_i = 0;
  endtask

  // monitor: compare each done against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R8 unexpected done actual=%h expected=none", sum_o);
      end else begin
        chk("R8 final sum", sum_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; in_valid_i = 0; in_last_i = 0; prot_on_i = 0;
    in_data_i = 16'hDEAD; in_region_i = 0; in_mask_i = 8'hFF; exp_sum = 0;
    repeat (3) @(negedge clk);
    chk("R1 sum in reset", sum_o, 16'h0);
    chk("R1 done in reset", {15'h0, done_o}, 16'h0);
    chk("R1 ready in reset", {15'h0, in_ready_o}, 16'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 ready after release", {15'h0, in_ready_o}, 16'h1);

    // R2 program words, wrap at 16 bits
    do_start();
    chk("R6 start clears", sum_o, 16'h0);
    send(0, 2'd0, 16'hFFFF, 8'h00, 0);
    send(0, 2'd0, 16'h0002, 8'h00, 0);
    chk("R2 wrap / R9 running", sum_o, 16'h0001);
    send(0, 2'd0, 16'h1234, 8'h00, 1);
    chk("R8 done pulse one cycle", {15'h0, done_o}, 16'h1);
    idle();
    chk("R8 done drops", {15'h0, done_o}, 16'h0);

    // R3 config masking, upper byte ignored
    do_start();
    send(0, 2'd1, 16'hABF3, 8'h0F, 0);
    chk("R3 masked byte", sum_o, 16'h0003);
    send(0, 2'd1, 16'h77FF, 8'hC5, 1);
    idle();

    // R4 ID gated by protection
    prot_on_i = 0;
    do_start();
    send(0, 2'd2, 16'h1111, 8'h00, 0);
    chk("R4 ID dropped when unprotected", sum_o, 16'h0000);
    chk("R4 ready while ID dropped", {15'h0, in_ready_o}, 16'h1);
    send(0, 2'd0, 16'h0001, 8'h00, 1);
    idle();
    prot_on_i = 1;
    do_start();
    send(0, 2'd2, 16'h1111, 8'h00, 0);
    chk("R4 ID added when protected", sum_o, 16'h1111);
    send(0, 2'd0, 16'h0001, 8'h00, 1);
    idle();
    prot_on_i = 0;

    // R5 EEPROM dropped
    do_start();
    send(0, 2'd3, 16'hFFFF, 8'hFF, 0);
    chk("R5 EEPROM no effect", sum_o, 16'h0000);
    send(0, 2'd0, 16'h0005, 8'h00, 0);
    send(0, 2'd3, 16'h1234, 8'hFF, 1);
    idle();

    // R7 valid low holds the sum
    do_start();
    send(0, 2'd0, 16'h0300, 8'h00, 0);
    in_valid_i = 0; in_data_i = 16'hBEEF; in_region_i = 2'd0; in_last_i = 1;
    repeat (3) @(negedge clk);
    chk("R7 idle holds sum", sum_o, 16'h0300);
    chk("R7 no done without valid", {15'h0, done_o}, 16'h0);
    in_last_i = 0;

    // R6 start and beat in the same cycle
    send(1, 2'd0, 16'h0042, 8'h00, 0);
    chk("R6 start with beat", sum_o, 16'h0042);
    send(0, 2'd1, 16'h0010, 8'hFF, 1);
    idle();
    idle();

    chk("R8 all done seen", exp_q.size(), 16'h0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule